// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside the request pipeline of a first-level cache controller and decides whether each store-conditional may write. Every hardware thread owns one reservation slot. A load-linked fills the slot with the line address of its byte address. From then on the block watches every committed store, every load-linked from another thread, and every line-removal event from the cache side. Any of these that hits the reserved line drops the reservation. When the store-conditional arrives, the verdict is resolved in the same cycle. A failing store-conditional never produces a write enable.

To stop competing threads from livelocking each other, a load-linked also opens a lockout window for a set number of cycles. While the window is open, plain loads and stores from other threads to the reserved line are stalled. A flush aimed at that line is refused and reported as failed. The window closes when the owner's store-conditional arrives or when its timer runs out. The reservation itself outlives the window, but it is exposed to conflicts again once the window has closed.

Top module: `llsc_monitor`

## Requirements
- R1: Addresses are compared at line granularity. Two byte addresses that differ only in their low log2(LINE_BYTES) bits name the same line.
- R2: A store-conditional (req_op=4) from the thread that issued the most recent load-linked (req_op=3) to the same line passes if no conflict came in between. sc_valid, sc_pass and wr_commit are then all high in that same cycle.
- R3: A committed plain store (req_op=2) to the reserved line drops the reservation, even when the storing thread is the owner. A later store-conditional to that line fails.
- R4: A load-linked from a different thread to the same line drops the first thread's reservation. The newer one holds.
- R5: Snoop events of kind evict (0), downgrade (1) or invalidate (3) that hit the reserved line drop the reservation. So does a flush (2) that hits it while its window is closed.
- R6: Stores, load-linked requests and snoop events that target other lines leave a reservation intact.
- R7: lock_open[t] rises in the cycle after thread t's load-linked and stays high for exactly TIMEOUT_CYCLES cycles unless something closes it early. A new load-linked from the same thread restarts the full count.
- R8: While thread t's window is open, a plain load (1) or store (2) from any other thread to that line sees req_stall high in the same cycle. A stalled store does not commit and does not drop the reservation. The owner's own plain accesses are never stalled.
- R9: A passing store-conditional closes the window in the next cycle. After the window expires, stalls to that line stop, and the reservation remains valid until a conflict drops it.
- R10: A failing store-conditional leaves wr_commit low and sc_pass low while sc_valid is high.
- R11: A flush snoop that hits a line inside an open window raises snp_flush_fail in the same cycle and leaves the reservation valid.
- R12: Any store-conditional, whether it passes or fails, consumes the issuing thread's reservation. A second store-conditional to the same line then fails.
- R13: After reset no thread holds a reservation and every lock_open bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 idle, 1 load, 2 store, 3 load-linked, 4 store-conditional |
| req_addr | input | ADDR_W | Request byte address |
| req_tid | input | TID_W | Issuing hardware thread |
| snp_valid | input | 1 | Cache-side event present this cycle |
| snp_kind | input | 2 | 0 evict, 1 downgrade, 2 flush, 3 invalidate |
| snp_addr | input | ADDR_W | Byte address of the cache-side event |
| req_stall | output | 1 | Plain access blocked by another thread's window |
| wr_commit | output | 1 | Data write allowed (unstalled store or passing store-conditional) |
| sc_valid | output | 1 | Store-conditional verdict present |
| sc_pass | output | 1 | Store-conditional verdict: 1 pass, 0 fail |
| snp_flush_fail | output | 1 | Flush refused because its line is inside an open window |
| lock_open | output | NUM_THREADS | Per-thread lockout window state |

## Verification
The bench builds the block with four threads, 32-bit addresses, 64-byte lines and an 8-cycle window. The short window makes the exact open interval, the expiry point and the restart on a repeated load-linked observable cycle by cycle. It also lets tests wait the window out before exercising conflicts that the window would otherwise stall. Four threads allow owner, competitor and bystander roles to be tested at once, and 64-byte lines put offsets such as 0x30 inside a line and 0x40 in the next one.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_LOAD  = 3'd1,
      OP_STORE = 3'd2,
      OP_LL    = 3'd3,
      OP_SC    = 3'd4
   } req_op_e;

   typedef enum logic [1:0] {
      SN_EVICT     = 2'd0,
      SN_DOWNGRADE = 2'd1,
      SN_FLUSH     = 2'd2,
      SN_INVAL     = 2'd3
   } snoop_kind_e;
endpackage

// File: rtl/llsc_line_map.sv
module llsc_line_map #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int LINE_W     = ADDR_W - $clog2(LINE_BYTES)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [LINE_W-1:0] line_o
);
   localparam int OFS_W = $clog2(LINE_BYTES);

   generate
      if (LINE_BYTES < 1 || (LINE_BYTES & (LINE_BYTES - 1)) != 0)
         $error("LINE_BYTES must be a power of two");
      if (LINE_W != ADDR_W - OFS_W)
         $error("LINE_W inconsistent with ADDR_W and LINE_BYTES");

      if (OFS_W == 0) begin : g_byte_lines
         assign line_o = addr_i;
      end else begin : g_wide_lines
         logic unused_ofs;
         assign unused_ofs = ^addr_i[OFS_W-1:0];
         assign line_o     = addr_i[ADDR_W-1:OFS_W];
      end
   endgenerate
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
   parameter int LINE_W         = 26,
   parameter int TIMEOUT_CYCLES = 16,
   parameter int CNT_W          = $clog2(TIMEOUT_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [LINE_W-1:0] set_line_i,
   input  logic              kill_i,
   output logic              valid_o,
   output logic [LINE_W-1:0] line_o,
   output logic              open_o
);
   logic [CNT_W-1:0] win_q;

   generate
      if (TIMEOUT_CYCLES < 1)
         $error("TIMEOUT_CYCLES must be at least 1");
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         line_o  <= '0;
         win_q   <= '0;
      end else if (set_i) begin
         valid_o <= 1'b1;
         line_o  <= set_line_i;
         win_q   <= CNT_W'(TIMEOUT_CYCLES);
      end else if (kill_i) begin
         valid_o <= 1'b0;
         win_q   <= '0;
      end else if (win_q != '0) begin
         win_q   <= win_q - 1'b1;
      end
   end

   assign open_o = valid_o && (win_q != '0);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
   parameter int NUM_THREADS    = 4,
   parameter int ADDR_W         = 32,
   parameter int LINE_BYTES     = 64,
   parameter int TIMEOUT_CYCLES = 16,
   parameter int TID_W          = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [2:0]             req_op,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [TID_W-1:0]       req_tid,
   input  logic                   snp_valid,
   input  logic [1:0]             snp_kind,
   input  logic [ADDR_W-1:0]      snp_addr,
   output logic                   req_stall,
   output logic                   wr_commit,
   output logic                   sc_valid,
   output logic                   sc_pass,
   output logic                   snp_flush_fail,
   output logic [NUM_THREADS-1:0] lock_open
);
   import llsc_pkg::*;

   localparam int LINE_W = ADDR_W - $clog2(LINE_BYTES);

   generate
      if (NUM_THREADS < 1)
         $error("NUM_THREADS must be at least 1");
      if (ADDR_W <= $clog2(LINE_BYTES))
         $error("ADDR_W too small for LINE_BYTES");
   endgenerate

   logic [LINE_W-1:0]      req_line, snp_line;
   logic [NUM_THREADS-1:0] slot_valid, own, hit, snp_hit, set_v, kill_v;
   logic [LINE_W-1:0]      slot_line [NUM_THREADS];
   logic                   is_plain, is_store, is_ll, is_sc;
   logic                   write_any, snp_kill;

   llsc_line_map #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LINE_W(LINE_W))
      u_req_map (.addr_i(req_addr), .line_o(req_line));
   llsc_line_map #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LINE_W(LINE_W))
      u_snp_map (.addr_i(snp_addr), .line_o(snp_line));

   assign is_store = req_valid && (req_op == OP_STORE);
   assign is_plain = req_valid && ((req_op == OP_LOAD) || (req_op == OP_STORE));
   assign is_ll    = req_valid && (req_op == OP_LL);
   assign is_sc    = req_valid && (req_op == OP_SC);

   genvar t;
   generate
      for (t = 0; t < NUM_THREADS; t++) begin : g_thr
         assign own[t]     = (req_tid == TID_W'(t));
         assign hit[t]     = slot_valid[t] && (slot_line[t] == req_line);
         assign snp_hit[t] = slot_valid[t] && (slot_line[t] == snp_line);
         assign set_v[t]   = is_ll && own[t];
         assign kill_v[t]  = (hit[t] && write_any)
                          || (hit[t] && is_ll && !own[t])
                          || (is_sc && own[t])
                          || (snp_hit[t] && snp_kill);

         llsc_resv_slot #(.LINE_W(LINE_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES))
            u_slot (
               .clk       (clk),
               .rst_n     (rst_n),
               .set_i     (set_v[t]),
               .set_line_i(req_line),
               .kill_i    (kill_v[t]),
               .valid_o   (slot_valid[t]),
               .line_o    (slot_line[t]),
               .open_o    (lock_open[t])
            );
      end
   endgenerate

   assign req_stall      = is_plain && |(lock_open & hit & ~own);
   assign sc_valid       = is_sc;
   assign sc_pass        = is_sc && |(hit & own);
   assign write_any      = (is_store && !req_stall) || sc_pass;
   assign wr_commit      = write_any;
   assign snp_flush_fail = snp_valid && (snp_kind == SN_FLUSH) && |(lock_open & snp_hit);
   assign snp_kill       = snp_valid && !snp_flush_fail;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
   parameter int NUM_THREADS    = 4,
   parameter int ADDR_W         = 32,
   parameter int LINE_BYTES     = 64,
   parameter int TIMEOUT_CYCLES = 16,
   parameter int TID_W          = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic [2:0]             req_op,
   input logic [ADDR_W-1:0]      req_addr,
   input logic [TID_W-1:0]       req_tid,
   input logic                   snp_valid,
   input logic [1:0]             snp_kind,
   input logic [ADDR_W-1:0]      snp_addr,
   input logic                   req_stall,
   input logic                   wr_commit,
   input logic                   sc_valid,
   input logic                   sc_pass,
   input logic                   snp_flush_fail,
   input logic [NUM_THREADS-1:0] lock_open
);
   localparam int RUN_W = $clog2(TIMEOUT_CYCLES + 2) + 1;

   logic unused_chk;
   assign unused_chk = ^{req_addr, snp_addr, snp_kind};

   p_stall_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_stall |-> req_valid && (req_op == 3'd1 || req_op == 3'd2) && !wr_commit);

   p_sc_fail_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && !sc_pass) |-> !wr_commit);

   p_flush_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush_fail |-> snp_valid && (|lock_open));

   p_ll_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd3) |=> lock_open[$past(req_tid)]);

   p_sc_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_valid && sc_pass) |=> !lock_open[$past(req_tid)]);

   genvar t;
   generate
      for (t = 0; t < NUM_THREADS; t++) begin : g_run
         logic [RUN_W-1:0] run_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               run_q <= '0;
            else if (req_valid && req_op == 3'd3 && req_tid == TID_W'(t))
               run_q <= '0;
            else if (lock_open[t])
               run_q <= run_q + 1'b1;
            else
               run_q <= '0;
         end

         p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
            lock_open[t] |-> (run_q < RUN_W'(TIMEOUT_CYCLES)));
      end
   endgenerate
endmodule

bind llsc_monitor llsc_monitor_chk #(
   .NUM_THREADS   (NUM_THREADS),
   .ADDR_W        (ADDR_W),
   .LINE_BYTES    (LINE_BYTES),
   .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
   .TID_W         (TID_W)
) u_chk (.*);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
   localparam int NT = 4;
   localparam int AW = 32;
   localparam int LB = 64;
   localparam int TO = 8;
   localparam int TW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [TW-1:0] req_tid = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_kind = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          req_stall, wr_commit, sc_valid, sc_pass, snp_flush_fail;
   logic [NT-1:0] lock_open;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic c_stall, c_commit, c_scv, c_scp, c_ffail;
   logic [NT-1:0] c_open;

   always #2.5 clk = ~clk;

   llsc_monitor #(.NUM_THREADS(NT), .ADDR_W(AW), .LINE_BYTES(LB),
                  .TIMEOUT_CYCLES(TO), .TID_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_tid(req_tid), .snp_valid(snp_valid),
      .snp_kind(snp_kind), .snp_addr(snp_addr), .req_stall(req_stall),
      .wr_commit(wr_commit), .sc_valid(sc_valid), .sc_pass(sc_pass),
      .snp_flush_fail(snp_flush_fail), .lock_open(lock_open));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic rv, input logic [2:0] op, input int tid,
                      input logic [AW-1:0] a, input logic sv,
                      input logic [1:0] k, input logic [AW-1:0] sa);
      @(negedge clk);
      req_valid = rv; req_op = op; req_tid = TW'(tid); req_addr = a;
      snp_valid = sv; snp_kind = k; snp_addr = sa;
      #1;
      c_stall = req_stall; c_commit = wr_commit; c_scv = sc_valid;
      c_scp = sc_pass; c_ffail = snp_flush_fail; c_open = lock_open;
   endtask

   task automatic rq(input logic [2:0] op, input int tid, input logic [AW-1:0] a);
      cyc(1'b1, op, tid, a, 1'b0, 2'd0, '0);
   endtask

   task automatic sn(input logic [1:0] k, input logic [AW-1:0] a);
      cyc(1'b0, 3'd0, 0, '0, 1'b1, k, a);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 0, '0, 1'b0, 2'd0, '0);
   endtask

   task automatic t_reset();
      idle(1);
      check("R13 lock_open after reset", c_open, 0);
      rq(3'd4, 0, 32'h100);
      check("R13 sc_valid", c_scv, 1);
      check("R13 no reservation after reset", c_scp, 0);
   endtask

   task automatic t_basic();
      rq(3'd3, 0, 32'h1000);
      rq(3'd4, 0, 32'h1030);
      check("R1 same line via other offset passes", c_scp, 1);
      check("R2 sc_valid", c_scv, 1);
      check("R2 wr_commit on pass", c_commit, 1);
   endtask

   task automatic t_own_store();
      rq(3'd3, 1, 32'h2000);
      rq(3'd2, 1, 32'h2008);
      check("R8 owner store not stalled", c_stall, 0);
      check("R3 owner store commits", c_commit, 1);
      rq(3'd4, 1, 32'h2000);
      check("R3 sc after own store fails", c_scp, 0);
      check("R10 failed sc no commit", c_commit, 0);
   endtask

   task automatic t_other_store();
      rq(3'd3, 0, 32'h3000);
      idle(TO);
      rq(3'd2, 2, 32'h3004);
      check("R9 no stall after expiry", c_stall, 0);
      check("R3 other store commits", c_commit, 1);
      rq(3'd4, 0, 32'h3000);
      check("R3 sc after other store fails", c_scp, 0);
      rq(3'd3, 0, 32'h4000);
      idle(TO + 1);
      rq(3'd4, 0, 32'h4000);
      check("R9 reservation survives expiry", c_scp, 1);
   endtask

   task automatic t_other_ll();
      rq(3'd3, 0, 32'h5000);
      rq(3'd3, 1, 32'h5010);
      rq(3'd4, 0, 32'h5000);
      check("R4 older reservation lost", c_scp, 0);
      rq(3'd4, 1, 32'h5000);
      check("R4 newer reservation holds", c_scp, 1);
   endtask

   task automatic t_snoop();
      for (int k = 0; k < 4; k++) begin
         if (k == 2) continue;
         rq(3'd3, 2, 32'h6000 + k * 32'h100);
         sn(2'(k), 32'h6020 + k * 32'h100);
         rq(3'd4, 2, 32'h6000 + k * 32'h100);
         check($sformatf("R5 snoop kind %0d kills", k), c_scp, 0);
      end
      rq(3'd3, 2, 32'h6800);
      idle(TO);
      sn(2'd2, 32'h6800);
      check("R5 flush outside window accepted", c_ffail, 0);
      rq(3'd4, 2, 32'h6800);
      check("R5 flush outside window kills", c_scp, 0);
   endtask

   task automatic t_other_lines();
      rq(3'd3, 3, 32'h7000);
      rq(3'd2, 0, 32'h7040);
      check("R6 store to next line commits", c_commit, 1);
      check("R6 store to next line not stalled", c_stall, 0);
      sn(2'd0, 32'h8000);
      rq(3'd3, 1, 32'h9000);
      rq(3'd4, 3, 32'h7000);
      check("R6 unrelated traffic keeps reservation", c_scp, 1);
   endtask

   task automatic t_window();
      rq(3'd3, 0, 32'hA000);
      rq(3'd1, 1, 32'hA010);
      check("R7 window open after ll", c_open[0], 1);
      check("R8 other load stalled", c_stall, 1);
      rq(3'd2, 2, 32'hA000);
      check("R8 other store stalled", c_stall, 1);
      check("R8 stalled store no commit", c_commit, 0);
      rq(3'd1, 0, 32'hA000);
      check("R8 owner load not stalled", c_stall, 0);
      rq(3'd4, 0, 32'hA000);
      check("R8 stalled store kept reservation", c_scp, 1);
      rq(3'd1, 1, 32'hA000);
      check("R9 window closed after sc", c_open[0], 0);
      check("R9 no stall after sc", c_stall, 0);
      rq(3'd3, 1, 32'hB000);
      idle(TO);
      check("R7 still open in last window cycle", c_open[1], 1);
      rq(3'd1, 2, 32'hB000);
      check("R7 closed after TIMEOUT_CYCLES", c_open[1], 0);
      check("R9 stall ends at expiry", c_stall, 0);
   endtask

   task automatic t_flush_window();
      rq(3'd3, 2, 32'hC000);
      sn(2'd2, 32'hC000);
      check("R11 flush in window refused", c_ffail, 1);
      rq(3'd4, 2, 32'hC000);
      check("R11 reservation kept after refused flush", c_scp, 1);
   endtask

   task automatic t_consume();
      rq(3'd3, 3, 32'hD000);
      rq(3'd4, 3, 32'hE000);
      check("R12 sc to other line fails", c_scp, 0);
      rq(3'd4, 3, 32'hD000);
      check("R12 reservation consumed", c_scp, 0);
      rq(3'd3, 0, 32'hF000);
      idle(5);
      rq(3'd3, 0, 32'hF000);
      idle(TO);
      check("R7 repeated ll restarts window", c_open[0], 1);
      idle(1);
      check("R7 restarted window ends", c_open[0], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_own_store();
      t_other_store();
      t_other_ll();
      t_snoop();
      t_other_lines();
      t_window();
      t_flush_window();
      t_consume();
      idle(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule